// File: doc/BRIEF.md
# Single-Wire ROM Command Selector

This block is the first command layer of a slave device on a single-wire bus. A bit-level bus engine, outside this block, decodes the line timing and hands over three kinds of event. The first is a bus reset. The second is a host write slot with its bit value. The third is a host read slot, during which the engine drives the line with the bit this block offers. After every bus reset, the block collects the first eight written bits, least significant bit first, and treats them as a ROM-level opcode.

The block holds a 64-bit identity. Bits 7:0 are the family code, bits 55:8 are the serial number and bits 63:56 are a CRC-8 taken over the lower 56 bits. Both the family code and the serial number are parameters, and the CRC is derived from them when the design is elaborated. There are three valid opcodes. One streams the identity out. One compares 64 host-written bits against the identity. One grants access directly.

The output is a `selected` flag that enables the memory command layer. The block checks no CRC itself. Whether the host is satisfied with what it reads back is the host's decision.

Top module: `swire_rom_select`

## Requirements
- R1: After `rstN` is asserted or a bus reset, `selected` is 0 and `txBit` is 1.
- R2: The opcode is made from the first eight write slots after a reset. The first slot gives bit 0 and the eighth slot gives bit 7.
- R3: Opcode CCh sets `selected` right after its eighth bit, with no identity transfer.
- R4: After opcode 33h, `txBit` offers identity bit k before read slot k, for k = 0..63. Bits 7:0 are the family code (default 09h), bits 55:8 are the serial number and bits 63:56 are the CRC. `selected` is set after the 64th slot.
- R5: The CRC byte is the CRC-8 of identity bits 0..55, fed bit 0 first. It uses polynomial x^8+x^5+x^4+1 in reflected form (mask 8Ch) with an initial value of 0.
- R6: After opcode 55h, the next 64 write slots are compared in order against identity bits 0..63. If all 64 match, `selected` is set after the 64th slot.
- R7: A mismatch on any compared bit puts the block in a muted state until the next reset. It is never selected there, read slots return 1 and write slots have no effect.
- R8: Any other opcode leaves the block unselected and muted until the next reset. A later CCh pattern does not select it.
- R9: A bus reset in any state, including part way through a transfer or while selected, clears `selected` and restarts opcode collection.
- R10: Read slots taken before the opcode is complete return 1 and do not disturb opcode collection.
- R11: Once selected, further read and write slots leave `selected` at 1 and `txBit` at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | One-cycle strobe: reset pulse detected on the bus |
| wrSlot | input | 1 | One-cycle strobe: host write slot finished |
| wrBit | input | 1 | Bit value of the write slot |
| rdSlot | input | 1 | One-cycle strobe: host read slot taken |
| txBit | output | 1 | Bit offered for the current read slot; 1 releases the line |
| selected | output | 1 | Access to the memory command layer granted |

## Verification
Every one of the 256 opcode values is sent after a reset. This separates the one opcode that selects at once from the two that start a transfer and from the 253 that mute the block. The identity read is compared bit by bit against an identity and CRC that the bench computes itself, which separates the field order, the bit order and the CRC polynomial. The match sequence is run once with the correct identity and 64 more times with exactly one bit flipped at each position, which shows that every bit position takes part in the comparison. Resets placed part way through a read and while selected show that a transfer can be abandoned at any point.

// File: rtl/swire_rom_pkg.sv
package swire_rom_pkg;

  localparam logic [7:0] OP_SEND_ID  = 8'h33;
  localparam logic [7:0] OP_MATCH_ID = 8'h55;
  localparam logic [7:0] OP_BYPASS   = 8'hCC;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_SEND,
    ST_COMPARE,
    ST_GRANTED,
    ST_MUTE
  } romState_t;

  typedef struct packed {
    logic shiftOp;
    logic advCnt;
    logic clrCnt;
  } romStb_t;

  // Reflected CRC-8 (mask 8Ch), initial value 0, bit 0 first.
  function automatic logic [7:0] idCrc(input logic [55:0] data);
    logic [7:0] acc;
    logic fb;
    acc = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb  = acc[0] ^ data[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ 8'h8C;
    end
    return acc;
  endfunction

endpackage

// File: rtl/swire_rom_dp.sv
module swire_rom_dp
  import swire_rom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h09,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_0000_0001,
  parameter int          ID_BITS     = 64,
  parameter int          OP_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  romStb_t              stb,
  input  logic                 wrBit,
  output logic [OP_BITS-1:0]   nextOp,
  output logic                 idBit,
  output logic                 opLast,
  output logic                 idLast
);
  localparam int CNT_W = $clog2(ID_BITS);
  localparam logic [55:0] ID_BODY = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [ID_BITS-1:0] ID_WORD = {idCrc(ID_BODY), ID_BODY};

  logic [OP_BITS-1:0] opReg;
  logic [CNT_W-1:0]   bitCnt;

  // The incoming bit enters at the top; after eight shifts the first bit is bit 0.
  assign nextOp = {wrBit, opReg[OP_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= '0;
    end else if (stb.shiftOp) begin
      opReg <= nextOp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (stb.clrCnt) begin
      bitCnt <= '0;
    end else if (stb.advCnt) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign idBit  = ID_WORD[bitCnt];
  assign opLast = (bitCnt == CNT_W'(OP_BITS - 1));
  assign idLast = (bitCnt == CNT_W'(ID_BITS - 1));

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrCnt |=> !opLast && !idLast) else $error("count not cleared"); // R9

endmodule

// File: rtl/swire_rom_ctrl.sv
module swire_rom_ctrl
  import swire_rom_pkg::*;
#(
  parameter int OP_BITS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               wrSlot,
  input  logic               wrBit,
  input  logic               rdSlot,
  input  logic [OP_BITS-1:0] nextOp,
  input  logic               idBit,
  input  logic               opLast,
  input  logic               idLast,
  output romStb_t            stb,
  output logic               txBit,
  output logic               selected
);
  romState_t st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_OPCODE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    stb    = '0;
    if (busReset) begin
      stNext     = ST_OPCODE;
      stb.clrCnt = 1'b1;
    end else begin
      unique case (st)
        ST_OPCODE: if (wrSlot) begin
          stb.shiftOp = 1'b1;
          if (opLast) begin
            stb.clrCnt = 1'b1;
            unique case (nextOp)
              OP_BYPASS:   stNext = ST_GRANTED;
              OP_SEND_ID:  stNext = ST_SEND;
              OP_MATCH_ID: stNext = ST_COMPARE;
              default:     stNext = ST_MUTE;
            endcase
          end else begin
            stb.advCnt = 1'b1;
          end
        end
        ST_SEND: if (rdSlot) begin
          if (idLast) begin
            stNext     = ST_GRANTED;
            stb.clrCnt = 1'b1;
          end else begin
            stb.advCnt = 1'b1;
          end
        end
        ST_COMPARE: if (wrSlot) begin
          if (wrBit != idBit) begin
            stNext     = ST_MUTE;
            stb.clrCnt = 1'b1;
          end else if (idLast) begin
            stNext     = ST_GRANTED;
            stb.clrCnt = 1'b1;
          end else begin
            stb.advCnt = 1'b1;
          end
        end
        default: stNext = st;
      endcase
    end
  end

  assign txBit    = (st == ST_SEND) ? idBit : 1'b1;
  assign selected = (st == ST_GRANTED);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!selected && st == ST_OPCODE)) else $error("reset ignored"); // R9
  AST_SEL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selected) |-> ($past(st) == ST_OPCODE || $past(st) == ST_SEND
                         || $past(st) == ST_COMPARE)) else $error("bad grant"); // R6
  AST_MUTE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_MUTE && !busReset) |=> (st == ST_MUTE)) else $error("mute left"); // R7
  AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !busReset) |=> selected) else $error("grant lost"); // R11

endmodule

// File: rtl/swire_rom_select.sv
module swire_rom_select
  import swire_rom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h09,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_0000_0001
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic wrSlot,
  input  logic wrBit,
  input  logic rdSlot,
  output logic txBit,
  output logic selected
);
  localparam int ID_BITS = 64;
  localparam int OP_BITS = 8;

  romStb_t            stb;
  logic [OP_BITS-1:0] nextOp;
  logic               idBit, opLast, idLast;

  swire_rom_ctrl #(.OP_BITS(OP_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrSlot(wrSlot),
    .wrBit(wrBit), .rdSlot(rdSlot), .nextOp(nextOp), .idBit(idBit),
    .opLast(opLast), .idLast(idLast), .stb(stb), .txBit(txBit),
    .selected(selected)
  );

  swire_rom_dp #(
    .FAMILY_CODE(FAMILY_CODE), .SERIAL_NUM(SERIAL_NUM),
    .ID_BITS(ID_BITS), .OP_BITS(OP_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBit(wrBit), .nextOp(nextOp),
    .idBit(idBit), .opLast(opLast), .idLast(idLast)
  );

  AST_GRANT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> txBit) else $error("line driven while granted"); // R11

endmodule

// File: tb/swire_rom_select_bench.sv
module swire_rom_select_bench;
  localparam logic [7:0]  FAM = 8'h09;
  localparam logic [47:0] SER = 48'hA5C3_1E72_9B04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, wrSlot = 1'b0, wrBit = 1'b0, rdSlot = 1'b0;
  logic txBit, selected;
  int nChecks = 0, nErr = 0;
  logic [63:0] idExp;
  logic [7:0]  crcExp;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  swire_rom_select #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_swire_rom_select (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrSlot(wrSlot),
    .wrBit(wrBit), .rdSlot(rdSlot), .txBit(txBit), .selected(selected)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slotW(input logic b);
    @(negedge clk); wrSlot = 1'b1; wrBit = b;
    @(negedge clk); wrSlot = 1'b0; wrBit = 1'b0;
  endtask

  task automatic slotR(output logic b);
    @(negedge clk); b = txBit; rdSlot = 1'b1;
    @(negedge clk); rdSlot = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) slotW(v[i]);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nErr++; nChecks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", nErr, nChecks);
        $finish;
      end
    end
  end

  initial begin
    logic b;
    logic [63:0] got;
    logic [7:0] c;
    // Expected CRC written out as per-bit update for mask 8Ch (R5).
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb;
      fb = c[0] ^ ({SER, FAM} >> i);
      c = {fb, c[7], c[6], c[5], c[4] ^ fb, c[3] ^ fb, c[2], c[1]};
    end
    crcExp = c;
    idExp  = {crcExp, SER, FAM};

    repeat (3) @(negedge clk);
    chk("R1 sel at rstN", selected, 0);
    chk("R1 tx at rstN", txBit, 1);
    rstN = 1'b1;
    @(negedge clk);

    // R10: read slots interleaved with opcode bits
    pulseReset();
    slotR(b); chk("R10 early read", b, 1);
    for (int i = 0; i < 4; i++) slotW(8'hCC >> i);
    slotR(b); chk("R10 mid read", b, 1);
    for (int i = 4; i < 8; i++) slotW(8'hCC >> i);
    chk("R10 opcode intact", selected, 1);

    // R2 R3 R8: sweep of all opcodes
    for (int op = 0; op < 256; op++) begin
      pulseReset();
      chk("R1 sel after bus reset", selected, 0);
      sendByte(8'(op));
      chk("R3 R2 select on opcode", selected, (op == 8'hCC) ? 1 : 0);
      if (op != 8'hCC && op != 8'h33 && op != 8'h55) begin
        sendByte(8'hCC);
        chk("R8 unknown opcode stays mute", selected, 0);
        slotR(b); chk("R8 muted read", b, 1);
      end
    end

    // R4 R5: identity stream
    pulseReset();
    sendByte(8'h33);
    got = '0;
    for (int k = 0; k < 64; k++) begin
      slotR(b); got[k] = b;
      chk("R4 identity bit", b, idExp[k]);
      if (k < 63) chk("R4 not yet selected", selected, 0);
    end
    chk("R4 family field", got[7:0], 8'h09);
    chk("R5 crc field", got[63:56], crcExp);
    chk("R4 selected after stream", selected, 1);

    // R11: slots ignored when granted
    slotW(1'b0); slotR(b);
    chk("R11 granted read", b, 1);
    chk("R11 stays selected", selected, 1);
    pulseReset();
    chk("R9 reset clears grant", selected, 0);

    // R6: correct match
    pulseReset();
    sendByte(8'h55);
    for (int k = 0; k < 64; k++) begin
      slotW(idExp[k]);
      if (k < 63) chk("R6 not early", selected, 0);
    end
    chk("R6 full match selects", selected, 1);

    // R7: single-bit mismatch at every position
    for (int m = 0; m < 64; m++) begin
      pulseReset();
      sendByte(8'h55);
      for (int k = 0; k < 64; k++) slotW(idExp[k] ^ (k == m));
      chk("R7 mismatch unselected", selected, 0);
      slotR(b); chk("R7 muted read", b, 1);
    end

    // R9: abort part way through the stream
    pulseReset();
    sendByte(8'h33);
    for (int k = 0; k < 10; k++) slotR(b);
    pulseReset();
    chk("R9 abort unselected", selected, 0);
    chk("R9 abort releases line", txBit, 1);
    sendByte(8'hCC);
    chk("R9 fresh opcode after abort", selected, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule